// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Not-Recently-Used Replacement

The block keeps a small, fully associative table of address translations. Each slot is tagged by a page-aligned virtual address, a page-size code, a partition number, a context number and a real-mode flag. It also holds a physical page and a lock flag. A lookup searches every slot in the same cycle and returns the physical address. That address is the physical page of the matching slot joined with the offset bits of the request.

Maintenance commands arrive on a single operation code, one per clock cycle:
- insert, either at a given slot or at a slot that the replacement logic picks;
- remove one page;
- remove one context;
- remove the unlocked slots of one partition;
- flush everything.

Replacement keeps one recently-used flag per slot. A new translation goes into the lowest slot that is empty or whose flag is clear. When the flags of all slots would be set, every flag is cleared except those of locked slots and of the slot just touched. Any slot can be read back by index as a packed tag word and its physical page.

The block has no state machine. One process holds the table registers. One combinational process decodes the operation code with a unique case. The commands are: none (0), insert (1), page removal (2), context removal (3), partition removal (4) and flush (5). Codes 6 and 7 do nothing.

Top module: `tlb_nru`

## Requirements
- R1: In the same cycle as the request, a lookup hits when a valid slot has equal partition, context and real flag and the request address lies within that slot's page. Page size code s gives 2^(13+3s) bytes. The hit returns the slot index and a physical address made of the slot's page bits and the request's offset bits.
- R2: An insert without an explicit index writes the lowest-numbered slot that is invalid or has a clear used flag. If there is no such slot, it writes the highest-numbered slot.
- R3: An insert with the index-enable input set writes exactly the given slot, whatever the used flags are.
- R4: An insert invalidates every other valid slot whose page overlaps the new page with equal partition, context and real flag, and clears that slot's used flag. A lookup therefore never matches more than one slot.
- R5: A lookup hit with the operation code at none sets the used flag of the hit slot. A lookup made in the same cycle as any maintenance command leaves the used flags unchanged.
- R6: An insert or a lookup hit that would leave all used flags set clears the used flags of all unlocked slots. The slot just inserted or hit keeps its flag.
- R7: Page removal invalidates the valid slot whose page contains the command address and whose partition, context and real flag are equal. A slot with a different context is untouched.
- R8: Context removal invalidates every slot whose partition and context both match, locked or not.
- R9: Partition removal invalidates every unlocked slot of the given partition and keeps the locked ones.
- R10: Flush invalidates every slot and clears every used flag.
- R11: The 64-bit readback tag holds:
  - the context in bits 12:0;
  - the page-aligned virtual address in bits 47:13;
  - the inverted size code in bits 57:56;
  - the real flag in bit 60;
  - the partition in bits 63:61.
  All other bits are zero. Stored addresses are aligned down to the page.
- R12: After reset every slot reads back invalid and no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Maintenance operation code |
| cmd_va_i | input | 48 | Command virtual address |
| cmd_pa_i | input | 40 | Physical page to insert |
| cmd_part_i | input | 3 | Command partition |
| cmd_ctx_i | input | 13 | Command context |
| cmd_real_i | input | 1 | Command real-mode flag |
| cmd_size_i | input | 2 | Page size code of the insert |
| cmd_lock_i | input | 1 | Lock flag of the insert |
| cmd_idx_en_i | input | 1 | Insert at cmd_idx_i instead of the chosen victim |
| cmd_idx_i | input | log2(NUM_ENTRIES) | Explicit insert slot |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 48 | Lookup virtual address |
| lk_part_i | input | 3 | Lookup partition |
| lk_ctx_i | input | 13 | Lookup context |
| lk_real_i | input | 1 | Lookup real-mode flag |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | log2(NUM_ENTRIES) | Index of the hit slot |
| lk_pa_o | output | 40 | Translated physical address |
| rd_idx_i | input | log2(NUM_ENTRIES) | Readback slot |
| rd_valid_o | output | 1 | Readback slot valid |
| rd_lock_o | output | 1 | Readback slot locked |
| rd_tag_o | output | 64 | Readback packed tag |
| rd_pa_o | output | 40 | Readback physical page |

## Verification
A lookup and a maintenance command can fall in the same clock cycle. The lookup still answers in that cycle, but its used-flag update must be dropped. The bench provokes this by holding a lookup of an unused slot during an automatic insert. It then judges the outcome from the next automatic insert, which must land on that same slot because its flag was never set. The saturation clearing and the lock protection are judged the same way, from where the following victim lands.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W         = 48;
    parameter int PA_W         = 40;
    parameter int CTX_W        = 13;
    parameter int PART_W       = 3;
    parameter int SZ_W         = 2;
    parameter int PG_SHIFT     = 13;
    parameter int SZ_STEP      = 3;
    parameter int TAG_W        = 64;
    parameter int TAG_SZ_LSB   = 56;
    parameter int TAG_REAL_BIT = 60;
    parameter int TAG_PART_LSB = 61;
    parameter int MAX_ENTRIES  = 64;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_INSERT     = 3'd1,
        OP_DEMAP_PAGE = 3'd2,
        OP_DEMAP_CTX  = 3'd3,
        OP_DEMAP_PART = 3'd4,
        OP_FLUSH      = 3'd5
    } tlb_op_e;

    typedef struct packed {
        logic              valid;
        logic              lock;
        logic              is_real;
        logic [PART_W-1:0] part;
        logic [CTX_W-1:0]  ctx;
        logic [SZ_W-1:0]   size;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   pa;
    } tlb_entry_t;

    function automatic logic [VA_W-1:0] va_page_mask(input logic [SZ_W-1:0] sz);
        return {VA_W{1'b1}} << (PG_SHIFT + SZ_STEP * int'(sz));
    endfunction

    function automatic logic [PA_W-1:0] pa_page_mask(input logic [SZ_W-1:0] sz);
        return {PA_W{1'b1}} << (PG_SHIFT + SZ_STEP * int'(sz));
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t        ent_i [N],
    input  logic [VA_W-1:0]   key_va_i,
    input  logic [PART_W-1:0] key_part_i,
    input  logic [CTX_W-1:0]  key_ctx_i,
    input  logic              key_real_i,
    input  logic [SZ_W-1:0]   key_size_i,
    input  logic              span_i,
    output logic [N-1:0]      match_o
);
    logic [VA_W-1:0] key_mask;
    assign key_mask = span_i ? va_page_mask(key_size_i) : {VA_W{1'b1}};

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [VA_W-1:0] mask;
        logic            same_id;
        assign mask    = va_page_mask(ent_i[g].size) & key_mask;
        assign same_id = (ent_i[g].part == key_part_i) && (ent_i[g].ctx == key_ctx_i)
                      && (ent_i[g].is_real == key_real_i);
        assign match_o[g] = ent_i[g].valid && same_id
                         && (((ent_i[g].va ^ key_va_i) & mask) == '0);
    end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_nru.sv
module tlb_nru
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        op_i,
    input  logic [VA_W-1:0]   cmd_va_i,
    input  logic [PA_W-1:0]   cmd_pa_i,
    input  logic [PART_W-1:0] cmd_part_i,
    input  logic [CTX_W-1:0]  cmd_ctx_i,
    input  logic              cmd_real_i,
    input  logic [SZ_W-1:0]   cmd_size_i,
    input  logic              cmd_lock_i,
    input  logic              cmd_idx_en_i,
    input  logic [IDX_W-1:0]  cmd_idx_i,
    input  logic              lk_req_i,
    input  logic [VA_W-1:0]   lk_va_i,
    input  logic [PART_W-1:0] lk_part_i,
    input  logic [CTX_W-1:0]  lk_ctx_i,
    input  logic              lk_real_i,
    output logic              lk_hit_o,
    output logic [IDX_W-1:0]  lk_idx_o,
    output logic [PA_W-1:0]   lk_pa_o,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_valid_o,
    output logic              rd_lock_o,
    output logic [TAG_W-1:0]  rd_tag_o,
    output logic [PA_W-1:0]   rd_pa_o
);
    localparam int N = NUM_ENTRIES;   // must stay at or below MAX_ENTRIES

    tlb_op_e          op;
    tlb_entry_t       ent_q [N];
    tlb_entry_t       ent_d [N];
    logic [N-1:0]     used_q, used_d;
    logic [N-1:0]     valid_vec, lock_vec, lock_d, keep;
    logic [N-1:0]     lk_match, cmd_match, free_vec;
    logic             lk_found, free_found;
    logic [IDX_W-1:0] free_idx, tgt_idx;
    tlb_entry_t       hit_ent, rd_ent, new_ent;

    assign op = tlb_op_e'(op_i);

    for (genvar g = 0; g < N; g++) begin : g_vec
        assign valid_vec[g] = ent_q[g].valid;
        assign lock_vec[g]  = ent_q[g].lock;
        assign lock_d[g]    = ent_d[g].lock;
    end
    assign free_vec = ~valid_vec | ~used_q;

    tlb_match #(.N(N)) u_lk_match (
        .ent_i(ent_q), .key_va_i(lk_va_i), .key_part_i(lk_part_i),
        .key_ctx_i(lk_ctx_i), .key_real_i(lk_real_i), .key_size_i('0),
        .span_i(1'b0), .match_o(lk_match)
    );

    tlb_match #(.N(N)) u_cmd_match (
        .ent_i(ent_q), .key_va_i(cmd_va_i), .key_part_i(cmd_part_i),
        .key_ctx_i(cmd_ctx_i), .key_real_i(cmd_real_i), .key_size_i(cmd_size_i),
        .span_i(op == OP_INSERT), .match_o(cmd_match)
    );

    tlb_prio #(.N(N), .IDX_W(IDX_W)) u_hit_prio (
        .req_i(lk_match), .found_o(lk_found), .idx_o(lk_idx_o)
    );

    tlb_prio #(.N(N), .IDX_W(IDX_W)) u_victim (
        .req_i(free_vec), .found_o(free_found), .idx_o(free_idx)
    );

    // lookup result
    assign hit_ent  = ent_q[lk_idx_o];
    assign lk_hit_o = lk_req_i && lk_found;
    assign lk_pa_o  = (hit_ent.pa & pa_page_mask(hit_ent.size))
                    | (PA_W'(lk_va_i) & ~pa_page_mask(hit_ent.size));

    // readback
    assign rd_ent     = ent_q[rd_idx_i];
    assign rd_valid_o = rd_ent.valid;
    assign rd_lock_o  = rd_ent.lock;
    assign rd_pa_o    = rd_ent.pa;
    always_comb begin
        rd_tag_o = '0;
        rd_tag_o[VA_W-1:0] = rd_ent.va;
        rd_tag_o[CTX_W-1:0] = rd_tag_o[CTX_W-1:0] | rd_ent.ctx;
        rd_tag_o[TAG_SZ_LSB +: SZ_W] = ~rd_ent.size;
        rd_tag_o[TAG_REAL_BIT] = rd_ent.is_real;
        rd_tag_o[TAG_PART_LSB +: PART_W] = rd_ent.part;
    end

    assign tgt_idx = cmd_idx_en_i ? cmd_idx_i
                   : (free_found ? free_idx : IDX_W'(N - 1));

    always_comb begin
        new_ent.valid   = 1'b1;
        new_ent.lock    = cmd_lock_i;
        new_ent.is_real = cmd_real_i;
        new_ent.part    = cmd_part_i;
        new_ent.ctx     = cmd_ctx_i;
        new_ent.size    = cmd_size_i;
        new_ent.va      = cmd_va_i & va_page_mask(cmd_size_i);
        new_ent.pa      = cmd_pa_i & pa_page_mask(cmd_size_i);
    end

    // next-state decode
    always_comb begin
        ent_d  = ent_q;
        used_d = used_q;
        keep   = '0;
        unique case (op)
            OP_NONE: begin
                if (lk_hit_o && !used_q[lk_idx_o]) begin
                    used_d[lk_idx_o] = 1'b1;
                    keep[lk_idx_o]   = 1'b1;
                end
            end
            OP_INSERT: begin
                for (int i = 0; i < N; i++) begin
                    if (cmd_match[i] && (IDX_W'(i) != tgt_idx)) begin
                        ent_d[i].valid = 1'b0;
                        used_d[i]      = 1'b0;
                    end
                end
                ent_d[tgt_idx]  = new_ent;
                used_d[tgt_idx] = 1'b1;
                keep[tgt_idx]   = 1'b1;
            end
            OP_DEMAP_PAGE: begin
                for (int i = 0; i < N; i++) begin
                    if (cmd_match[i]) begin
                        ent_d[i].valid = 1'b0;
                        used_d[i]      = 1'b0;
                    end
                end
            end
            OP_DEMAP_CTX: begin
                for (int i = 0; i < N; i++) begin
                    if (ent_q[i].part == cmd_part_i && ent_q[i].ctx == cmd_ctx_i) begin
                        ent_d[i].valid = 1'b0;
                        used_d[i]      = 1'b0;
                    end
                end
            end
            OP_DEMAP_PART: begin
                for (int i = 0; i < N; i++) begin
                    if (ent_q[i].part == cmd_part_i && !ent_q[i].lock) begin
                        ent_d[i].valid = 1'b0;
                        used_d[i]      = 1'b0;
                    end
                end
            end
            OP_FLUSH: begin
                for (int i = 0; i < N; i++) ent_d[i].valid = 1'b0;
                used_d = '0;
            end
            default: ;
        endcase
        if ((keep != '0) && (&used_d)) used_d = (used_d & lock_d) | keep;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
            used_q <= '0;
        end else begin
            ent_q  <= ent_d;
            used_q <= used_d;
        end
    end
endmodule

// File: rtl/tlb_nru_chk.sv
module tlb_nru_chk
    import tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [2:0]       op_i,
    input logic             cmd_idx_en_i,
    input logic [IDX_W-1:0] cmd_idx_i,
    input logic             lk_hit_o,
    input logic [IDX_W-1:0] lk_idx_o,
    input logic [N-1:0]     lk_match,
    input logic [N-1:0]     valid_vec,
    input logic [N-1:0]     lock_vec,
    input logic [N-1:0]     used_q
);
    assert_single_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lk_match));

    assert_flush_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_FLUSH) |=> (valid_vec == '0) && (used_q == '0));

    assert_index_insert_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_INSERT && cmd_idx_en_i) |=> valid_vec[$past(cmd_idx_i)]);

    assert_used_only_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (used_q & ~valid_vec) == '0);

    assert_hit_marks_used_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_NONE && lk_hit_o) |=> used_q[$past(lk_idx_o)]);

    assert_no_saturation_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_INSERT) |=> !(&used_q) || ($countones(lock_vec) >= N - 1));
endmodule

bind tlb_nru tlb_nru_chk #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .cmd_idx_en_i(cmd_idx_en_i),
    .cmd_idx_i(cmd_idx_i), .lk_hit_o(lk_hit_o), .lk_idx_o(lk_idx_o),
    .lk_match(lk_match), .valid_vec(valid_vec), .lock_vec(lock_vec), .used_q(used_q)
);

// File: tb/tlb_nru_test.sv
module tlb_nru_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [47:0] cva = '0;
    logic [39:0] cpa = '0;
    logic [2:0]  cpart = '0;
    logic [12:0] cctx = '0;
    logic        creal = 1'b0;
    logic [1:0]  csize = '0;
    logic        clock_f = 1'b0;
    logic        cidx_en = 1'b0;
    logic [3:0]  cidx = '0;
    logic        lreq = 1'b0;
    logic [47:0] lva = '0;
    logic [2:0]  lpart = '0;
    logic [12:0] lctx = '0;
    logic        lreal = 1'b0;
    logic        lhit;
    logic [3:0]  lidx;
    logic [39:0] lpa;
    logic [3:0]  ridx = '0;
    logic        rvalid, rlock;
    logic [63:0] rtag;
    logic [39:0] rpa;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    tlb_nru #(.NUM_ENTRIES(16)) uut (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .cmd_va_i(cva), .cmd_pa_i(cpa),
        .cmd_part_i(cpart), .cmd_ctx_i(cctx), .cmd_real_i(creal), .cmd_size_i(csize),
        .cmd_lock_i(clock_f), .cmd_idx_en_i(cidx_en), .cmd_idx_i(cidx),
        .lk_req_i(lreq), .lk_va_i(lva), .lk_part_i(lpart), .lk_ctx_i(lctx),
        .lk_real_i(lreal), .lk_hit_o(lhit), .lk_idx_o(lidx), .lk_pa_o(lpa),
        .rd_idx_i(ridx), .rd_valid_o(rvalid), .rd_lock_o(rlock), .rd_tag_o(rtag),
        .rd_pa_o(rpa)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_tag(input logic [2:0] part, input logic [12:0] ctx,
                                           input logic rl, input logic [1:0] sz,
                                           input logic [47:0] va);
        logic [47:0] m;
        m = {48{1'b1}} << (13 + 3 * int'(sz));
        return {part, rl, 2'b00, ~sz, 8'h00, (va & m)} | {51'b0, ctx};
    endfunction

    task automatic cmd(input logic [2:0] o, input logic [47:0] va, input logic [39:0] pa,
                       input logic [2:0] part, input logic [12:0] ctx, input logic rl,
                       input logic [1:0] sz, input logic lk, input logic ie,
                       input logic [3:0] ix);
        @(negedge clk);
        op = o; cva = va; cpa = pa; cpart = part; cctx = ctx; creal = rl;
        csize = sz; clock_f = lk; cidx_en = ie; cidx = ix;
        @(negedge clk);
        op = 3'd0; cidx_en = 1'b0;
    endtask

    task automatic ins(input logic [47:0] va, input logic [2:0] part, input logic [12:0] ctx,
                       input logic lk);
        cmd(3'd1, va, {va[39:0]} ^ 40'h80_0000_0000, part, ctx, 1'b0, 2'd0, lk, 1'b0, 4'd0);
    endtask

    task automatic look(input logic [47:0] va, input logic [2:0] part, input logic [12:0] ctx,
                        input logic rl, output logic hit, output logic [3:0] ix,
                        output logic [39:0] pa);
        @(negedge clk);
        lva = va; lpart = part; lctx = ctx; lreal = rl; lreq = 1'b1;
        #1;
        hit = lhit; ix = lidx; pa = lpa;
        @(negedge clk);
        lreq = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ix);
        ridx = ix;
        #1;
    endtask

    task automatic flush();
        cmd(3'd5, '0, '0, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_reset();
        logic h; logic [3:0] ix; logic [39:0] pa;
        logic [15:0] v;
        for (int i = 0; i < 16; i++) begin rd(4'(i)); v[i] = rvalid; end
        check(v == 16'h0, "R12 all invalid after reset", 64'(v), 64'h0);
        look(48'h0, 3'd0, 13'd0, 1'b0, h, ix, pa);
        check(h == 1'b0, "R12 no hit after reset", 64'(h), 64'h0);
    endtask

    task automatic t_basic();
        logic h; logic [3:0] ix; logic [39:0] pa;
        cmd(3'd1, 48'h0000_1234_0000, 40'h00_ABCD_0000, 3'd1, 13'd7, 1'b0, 2'd1,
            1'b0, 1'b0, 4'd0);
        look(48'h0000_1234_BEEF, 3'd1, 13'd7, 1'b0, h, ix, pa);
        check(h && ix == 4'd0, "R2 first insert in slot 0", 64'(ix), 64'h0);
        check(pa == 40'h00_ABCD_BEEF, "R1 translated address", 64'(pa), 64'hABCDBEEF);
        look(48'h0000_1234_BEEF, 3'd1, 13'd8, 1'b0, h, ix, pa);
        check(!h, "R1 context mismatch misses", 64'(h), 64'h0);
        look(48'h0000_1234_BEEF, 3'd2, 13'd7, 1'b0, h, ix, pa);
        check(!h, "R1 partition mismatch misses", 64'(h), 64'h0);
        look(48'h0000_1234_BEEF, 3'd1, 13'd7, 1'b1, h, ix, pa);
        check(!h, "R1 real flag mismatch misses", 64'(h), 64'h0);
        look(48'h0000_1235_0000, 3'd1, 13'd7, 1'b0, h, ix, pa);
        check(!h, "R1 address outside page misses", 64'(h), 64'h0);
    endtask

    task automatic t_fill_saturate();
        logic h; logic [3:0] ix; logic [39:0] pa;
        flush();
        for (int i = 0; i < 16; i++) ins(48'h10_0000 + 48'(i) * 48'h2000, 3'd1, 13'd7, 1'b0);
        rd(4'd15);
        check(rtag == mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h10_0000 + 48'd15 * 48'h2000),
              "R2 sixteenth insert in slot 15", rtag, 64'h0);
        ins(48'h20_0000, 3'd1, 13'd7, 1'b0);
        rd(4'd0);
        check(rtag == mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h20_0000),
              "R6 saturation cleared, victim slot 0", rtag,
              mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h20_0000));
        look(48'h10_0000, 3'd1, 13'd7, 1'b0, h, ix, pa);
        check(!h, "R2 replaced page misses", 64'(h), 64'h0);
        look(48'h10_6000, 3'd1, 13'd7, 1'b0, h, ix, pa);
        check(h && ix == 4'd3, "R1 hit slot 3", 64'(ix), 64'h3);
        ins(48'h20_2000, 3'd1, 13'd7, 1'b0);
        ins(48'h20_4000, 3'd1, 13'd7, 1'b0);
        ins(48'h20_6000, 3'd1, 13'd7, 1'b0);
        rd(4'd4);
        check(rtag == mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h20_6000),
              "R5 hit slot 3 skipped, victim slot 4", rtag,
              mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h20_6000));
    endtask

    task automatic t_collision();
        @(negedge clk);
        op = 3'd1; cva = 48'h20_8000; cpa = 40'h1; cpart = 3'd1; cctx = 13'd7;
        creal = 1'b0; csize = 2'd0; clock_f = 1'b0; cidx_en = 1'b0;
        lva = 48'h10_C000; lpart = 3'd1; lctx = 13'd7; lreal = 1'b0; lreq = 1'b1;
        #1;
        check(lhit && lidx == 4'd6, "R1 lookup answers during insert", 64'(lidx), 64'h6);
        @(negedge clk);
        op = 3'd0; lreq = 1'b0;
        rd(4'd5);
        check(rtag == mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h20_8000),
              "R2 coincident insert in slot 5", rtag, 64'h0);
        ins(48'h20_A000, 3'd1, 13'd7, 1'b0);
        rd(4'd6);
        check(rtag == mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h20_A000),
              "R5 coincident lookup did not mark slot 6", rtag,
              mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h20_A000));
    endtask

    task automatic t_index_and_conflict();
        logic h; logic [3:0] ix; logic [39:0] pa;
        cmd(3'd1, 48'h30_0000, 40'h55_0000, 3'd1, 13'd7, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9);
        rd(4'd9);
        check(rvalid && rtag == mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h30_0000),
              "R3 explicit slot 9 written", rtag, 64'h0);
        look(48'h30_0010, 3'd1, 13'd7, 1'b0, h, ix, pa);
        check(h && ix == 4'd9 && pa == 40'h55_0010, "R3 lookup hits slot 9", 64'(pa),
              64'h55_0010);
        cmd(3'd1, 48'h30_0000, 40'h66_0000, 3'd1, 13'd7, 1'b0, 2'd1, 1'b0, 1'b1, 4'd12);
        rd(4'd9);
        check(!rvalid, "R4 overlapping slot 9 removed", 64'(rvalid), 64'h0);
        look(48'h30_4000, 3'd1, 13'd7, 1'b0, h, ix, pa);
        check(h && ix == 4'd12, "R4 larger page in slot 12", 64'(ix), 64'hC);
    endtask

    task automatic t_lock_part();
        logic [15:0] v;
        flush();
        for (int i = 0; i < 16; i++)
            ins(48'h50_0000 + 48'(i) * 48'h2000, 3'd1, 13'd7, (i < 2) ? 1'b1 : 1'b0);
        ins(48'h60_0000, 3'd1, 13'd7, 1'b0);
        rd(4'd2);
        check(rtag == mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h60_0000),
              "R6 locked slots keep used flag, victim slot 2", rtag, 64'h0);
        rd(4'd0);
        check(rlock == 1'b1, "R6 slot 0 reads back locked", 64'(rlock), 64'h1);
        cmd(3'd4, '0, '0, 3'd1, '0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0);
        for (int i = 0; i < 16; i++) begin rd(4'(i)); v[i] = rvalid; end
        check(v == 16'h0003, "R9 only locked slots survive", 64'(v), 64'h3);
    endtask

    task automatic t_demap_ctx();
        logic [3:0] v;
        flush();
        ins(48'h70_0000, 3'd1, 13'd5, 1'b1);
        ins(48'h70_2000, 3'd1, 13'd6, 1'b0);
        ins(48'h70_4000, 3'd2, 13'd5, 1'b0);
        ins(48'h70_6000, 3'd1, 13'd5, 1'b0);
        cmd(3'd3, '0, '0, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0);
        for (int i = 0; i < 4; i++) begin rd(4'(i)); v[i] = rvalid; end
        check(v == 4'b0110, "R8 context removal", 64'(v), 64'h6);
    endtask

    task automatic t_demap_page();
        logic [1:0] v;
        flush();
        ins(48'h40_0000, 3'd1, 13'd7, 1'b0);
        ins(48'h40_2000, 3'd1, 13'd7, 1'b0);
        cmd(3'd2, 48'h40_2123, '0, 3'd1, 13'd9, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0);
        for (int i = 0; i < 2; i++) begin rd(4'(i)); v[i] = rvalid; end
        check(v == 2'b11, "R7 wrong context leaves page", 64'(v), 64'h3);
        cmd(3'd2, 48'h40_2123, '0, 3'd1, 13'd7, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0);
        for (int i = 0; i < 2; i++) begin rd(4'(i)); v[i] = rvalid; end
        check(v == 2'b01, "R7 page removed, neighbour kept", 64'(v), 64'h1);
    endtask

    task automatic t_tag();
        logic h; logic [3:0] ix; logic [39:0] pa;
        cmd(3'd1, 48'h0000_7654_0000, 40'h12_3456_7000, 3'd5, 13'h0ABC, 1'b1, 2'd2,
            1'b0, 1'b1, 4'd3);
        rd(4'd3);
        check(rtag == 64'hB100_0000_7650_0ABC, "R11 packed tag", rtag, 64'hB100_0000_7650_0ABC);
        check(rpa == 40'h12_3450_0000, "R11 aligned physical page", 64'(rpa),
              64'h12_3450_0000);
        look(48'h0000_7657_1234, 3'd5, 13'h0ABC, 1'b1, h, ix, pa);
        check(h && ix == 4'd3 && pa == 40'h12_3457_1234, "R1 large page translation",
              64'(pa), 64'h12_3457_1234);
    endtask

    task automatic t_flush();
        logic h; logic [3:0] ix; logic [39:0] pa;
        logic [15:0] v;
        flush();
        for (int i = 0; i < 16; i++) begin rd(4'(i)); v[i] = rvalid; end
        check(v == 16'h0, "R10 flush invalidates all", 64'(v), 64'h0);
        look(48'h0000_7657_1234, 3'd5, 13'h0ABC, 1'b1, h, ix, pa);
        check(!h, "R10 no hit after flush", 64'(h), 64'h0);
        ins(48'h90_0000, 3'd1, 13'd7, 1'b0);
        rd(4'd0);
        check(rvalid && rtag == mk_tag(3'd1, 13'd7, 1'b0, 2'd0, 48'h90_0000),
              "R10 used flags cleared, victim slot 0", rtag, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_fill_saturate();
        t_collision();
        t_index_and_conflict();
        t_lock_part();
        t_demap_ctx();
        t_demap_page();
        t_tag();
        t_flush();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule